// File: doc/BRIEF.md
# UART Modem Line Control and Status

This block holds the modem-side state of a 16550-style serial port. Software writes a small control register that drives four modem output lines (data-terminal-ready, request-to-send and two general outputs) and a loopback switch. It reads a status register that reports the present level of four modem input lines (clear-to-send, data-set-ready, ring indicator, carrier detect) and a sticky change flag for each of them.

The input lines are asynchronous. Each passes through a two-flop synchroniser and is then compared against the level held from the previous cycle. A change sets the matching flag. The ring flag is set only when the ring line falls. The flags stay set until software reads the status register. The interrupt request is high whenever any flag is set. In loopback mode the status register shows the control outputs cross-wired onto the input positions, and the external lines have no effect.

A one-bit select picks between the two registers. Reads are combinational, and the clearing side effect of a status read takes place at the clock edge that ends the read cycle.

Top module: `uart_modem_port`

## Requirements
- R1: After reset the control register reads 0x08 and the interrupt request is low. With carrier, data-set-ready and clear-to-send held high and ring held low, the status register reads 0xB0.
- R2: Status bits 7..4 hold the levels of carrier, ring, data-set-ready and clear-to-send, in that order. A change on carrier, data-set-ready or clear-to-send sets bit 3, 1 or 0 respectively. A set bit stays set until a status read clears it.
- R3: Status bit 2 is set when the ring line goes from 1 to 0. It is never set when the ring line goes from 0 to 1.
- R4: A status read outside loopback clears bits 3..0 at the edge that ends the read. If a new change is detected in that same cycle, its bit is set and survives the clear.
- R5: The control register keeps only bits 4..0: bit 0 data-terminal-ready, bit 1 request-to-send, bit 2 general output 1, bit 3 general output 2, bit 4 loopback. Bits 7..5 read as 0. Bits 0..3 drive the four output pins directly.
- R6: In loopback (control bit 4 set) a status read returns general output 2 in bit 7, general output 1 in bit 6, data-terminal-ready in bit 5, request-to-send in bit 4, and 0 in bits 3..0.
- R7: In loopback, changes on the external lines set no flag and leave the interrupt unchanged. The held levels keep tracking the lines, so leaving loopback produces no flag for changes made while it was on.
- R8: The interrupt request is high exactly when any of status bits 3..0 is set.
- R9: A write with the status register selected changes neither register.
- R10: Select value 0 addresses the control register and 1 addresses the status register. An input change is visible in the status register by the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read clears flags) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| ri_in | input | 1 | Ring indicator line, asynchronous |
| dcd_in | input | 1 | Carrier detect line, asynchronous |
| dtr_out | output | 1 | Data-terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| gp1_out | output | 1 | General output 1 |
| gp2_out | output | 1 | General output 2 |
| modem_irq | output | 1 | Modem status interrupt request |

## Verification
The status read that clears the flags and the detection of a fresh line change can land in the same clock cycle. The bench provokes this by counting the synchroniser stages. It changes data-set-ready at a falling edge and starts a status read exactly two falling edges later, so the read ends on the edge where the new flag is written. The result is judged by two values. The read itself must show only the older clear-to-send flag. The read that follows must show the data-set-ready flag alone, which proves that the clear removed the old flag and did not swallow the new one.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;

  // Number of modem lines in each direction
  localparam int unsigned LINE_CNT = 4;

  // Index of each input line inside a line vector (matches status bits 7..4)
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DCD = 3;

  // Control register field positions
  localparam int unsigned CB_DTR  = 0;
  localparam int unsigned CB_RTS  = 1;
  localparam int unsigned CB_GP1  = 2;
  localparam int unsigned CB_GP2  = 3;
  localparam int unsigned CB_LOOP = 4;
  localparam int unsigned CTRL_W  = 5;

  localparam logic [CTRL_W-1:0] CTRL_RST = 5'b01000;

  typedef logic [LINE_CNT-1:0] line_vec_t;

  // Idle level of the input lines: carrier, data-set-ready, clear-to-send high
  localparam line_vec_t LINE_IDLE = 4'b1011;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/modem_line_sync.sv
module modem_line_sync #(
  parameter int unsigned             WIDTH   = 4,
  parameter int unsigned             STAGES  = 2,
  parameter logic [WIDTH-1:0]        RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_in;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
  import uart_modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [7:0]        wdata,
  output logic [CTRL_W-1:0] ctrl_bits
);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;

  always_comb begin
    ctrl_en = wr_ctrl;
    ctrl_d  = wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl_bits = ctrl_q;

endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import uart_modem_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t line_now,
  input  logic      loop_on,
  input  logic      rd_clr,
  output line_vec_t level_q,
  output line_vec_t delta_q
);

  line_vec_t lvl_q, lvl_d;
  line_vec_t dlt_q, dlt_d;
  line_vec_t diff, set_vec;
  logic      lvl_en, dlt_en;

  always_comb begin
    diff = lvl_q ^ line_now;
    set_vec = '0;
    if (!loop_on) begin
      set_vec[LN_CTS] = diff[LN_CTS];
      set_vec[LN_DSR] = diff[LN_DSR];
      set_vec[LN_DCD] = diff[LN_DCD];
      // ring flag only on a falling ring line
      set_vec[LN_RI]  = lvl_q[LN_RI] & ~line_now[LN_RI];
    end

    lvl_en = |diff;
    lvl_d  = line_now;

    // a flag raised in the read cycle wins over the clear
    dlt_en = rd_clr | (|set_vec);
    dlt_d  = (rd_clr ? '0 : dlt_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= LINE_IDLE;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dlt_q <= '0;
    else if (dlt_en) dlt_q <= dlt_d;
  end

  assign level_q = lvl_q;
  assign delta_q = dlt_q;

endmodule

// File: rtl/uart_modem_port.sv
module uart_modem_port
  import uart_modem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       ri_in,
  input  logic       dcd_in,
  output logic       dtr_out,
  output logic       rts_out,
  output logic       gp1_out,
  output logic       gp2_out,
  output logic       modem_irq
);

  localparam int unsigned PAD_W = 8 - CTRL_W;

  line_vec_t         raw_lines;
  line_vec_t         sync_lines;
  line_vec_t         cur_lvl;
  line_vec_t         delta_bits;
  logic [CTRL_W-1:0] ctrl_bits;
  logic              loop_on;
  logic              wr_ctrl;
  logic              rd_clr;
  logic [7:0]        stat_view;
  logic [7:0]        loop_view;

  always_comb begin
    raw_lines         = '0;
    raw_lines[LN_CTS] = cts_in;
    raw_lines[LN_DSR] = dsr_in;
    raw_lines[LN_RI]  = ri_in;
    raw_lines[LN_DCD] = dcd_in;
  end

  modem_line_sync #(
    .WIDTH   (LINE_CNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (LINE_IDLE)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_lines),
    .sync_out (sync_lines)
  );

  assign wr_ctrl = wr_en & (reg_sel == SEL_CTRL);

  modem_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wdata     (wdata),
    .ctrl_bits (ctrl_bits)
  );

  assign loop_on = ctrl_bits[CB_LOOP];
  assign rd_clr  = rd_en & (reg_sel == SEL_STAT) & ~loop_on;

  modem_status_reg u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_now (sync_lines),
    .loop_on  (loop_on),
    .rd_clr   (rd_clr),
    .level_q  (cur_lvl),
    .delta_q  (delta_bits)
  );

  always_comb begin
    stat_view = {cur_lvl, delta_bits};
    loop_view = '0;
    loop_view[4 + LN_DCD] = ctrl_bits[CB_GP2];
    loop_view[4 + LN_RI]  = ctrl_bits[CB_GP1];
    loop_view[4 + LN_DSR] = ctrl_bits[CB_DTR];
    loop_view[4 + LN_CTS] = ctrl_bits[CB_RTS];
    if (reg_sel == SEL_CTRL) rdata = {{PAD_W{1'b0}}, ctrl_bits};
    else if (loop_on)        rdata = loop_view;
    else                     rdata = stat_view;
  end

  assign dtr_out   = ctrl_bits[CB_DTR];
  assign rts_out   = ctrl_bits[CB_RTS];
  assign gp1_out   = ctrl_bits[CB_GP1];
  assign gp2_out   = ctrl_bits[CB_GP2];
  assign modem_irq = |delta_bits;

endmodule

// File: rtl/uart_modem_port_chk.sv
module uart_modem_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       dtr_out,
  input logic       rts_out,
  input logic       gp1_out,
  input logic       gp2_out,
  input logic       modem_irq,
  input logic       loop_on,
  input logic [3:0] sync_lines,
  input logic [3:0] cur_lvl
);

  assert_ctrl_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 1'b0) |-> (rdata[7:5] == 3'b000));

  assert_ctrl_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 1'b0) |=>
      ({gp2_out, gp1_out, rts_out, dtr_out} == $past(wdata[3:0])));

  assert_stat_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 1'b1) |=>
      $stable({gp2_out, gp1_out, rts_out, dtr_out, loop_on}));

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_irq && !(rd_en && reg_sel && !loop_on)) |=> modem_irq);

  assert_change_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_on && ((cur_lvl[3] != sync_lines[3]) || (cur_lvl[1] != sync_lines[1]) ||
                  (cur_lvl[0] != sync_lines[0]))) |=> modem_irq);

  assert_ring_rise_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!modem_irq && !cur_lvl[2] && ((cur_lvl ^ sync_lines) == 4'b0100)) |=> !modem_irq);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel && !loop_on && (cur_lvl == sync_lines)) |=> !modem_irq);

  assert_loop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && !modem_irq) |=> !modem_irq);

  assert_loop_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && reg_sel) |-> (rdata == {gp2_out, gp1_out, dtr_out, rts_out, 4'b0000}));

endmodule

bind uart_modem_port uart_modem_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel    (reg_sel),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .wdata      (wdata),
  .rdata      (rdata),
  .dtr_out    (dtr_out),
  .rts_out    (rts_out),
  .gp1_out    (gp1_out),
  .gp2_out    (gp2_out),
  .modem_irq  (modem_irq),
  .loop_on    (loop_on),
  .sync_lines (sync_lines),
  .cur_lvl    (cur_lvl)
);

// File: tb/uart_modem_port_test.sv
module uart_modem_port_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_sel, wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic       cts_in, dsr_in, ri_in, dcd_in;
  logic       dtr_out, rts_out, gp1_out, gp2_out, modem_irq;
  logic [3:0] lines;   // {dcd, ri, dsr, cts}

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  assign {dcd_in, ri_in, dsr_in, cts_in} = lines;

  always #10 clk = ~clk;

  uart_modem_port uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cts_in(cts_in), .dsr_in(dsr_in),
    .ri_in(ri_in), .dcd_in(dcd_in), .dtr_out(dtr_out), .rts_out(rts_out),
    .gp1_out(gp1_out), .gp2_out(gp2_out), .modem_irq(modem_irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_read(input logic sel, output logic [7:0] val);
    reg_sel = sel; rd_en = 1'b1;
    #5 val = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] val);
    reg_sel = sel; wdata = val; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [3:0] d;
    rst_n = 1'b0; reg_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = '0;
    lines = 4'b1011;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check("R1 irq", {7'b0, modem_irq}, 8'h00);
    reg_read(1'b0, v); check("R1 ctrl", v, 8'h08);
    reg_read(1'b1, v); check("R1 status", v, 8'hB0);

    // R5 / R10 control register sweep
    for (int c = 0; c < 32; c++) begin
      reg_write(1'b0, 8'(c));
      reg_read(1'b0, v); check("R5 ctrl readback", v, 8'(c));
      check("R5 pins", {4'b0, gp2_out, gp1_out, rts_out, dtr_out}, 8'(c & 15));
      if (c >= 16) begin
        // R6 loopback view
        reg_read(1'b1, v);
        check("R6 loop view", v, {c[3], c[2], c[0], c[1], 4'b0000});
      end
    end
    reg_write(1'b0, 8'hFF);
    reg_read(1'b0, v); check("R5 upper bits dropped", v, 8'h1F);
    reg_write(1'b0, 8'h08);

    // R9 write to status ignored
    reg_write(1'b1, 8'hFF);
    reg_read(1'b0, v); check("R9 ctrl unchanged", v, 8'h08);
    reg_read(1'b1, v); check("R9 status unchanged", v, 8'hB0);
    check("R9 irq", {7'b0, modem_irq}, 8'h00);

    // R2 R3 R4 R8 R10 all transitions
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        lines = 4'(o); idle(4);
        reg_read(1'b1, v);
        lines = 4'(n); idle(4);
        d = 4'(o ^ n);
        d[2] = o[2] & ~n[2];
        check("R8 irq level", {7'b0, modem_irq}, {7'b0, |d});
        reg_read(1'b1, v); check("R2/R3 flags", v, {4'(n), d});
        reg_read(1'b1, v); check("R4 cleared", v, {4'(n), 4'b0000});
      end
    end

    // R4 set and clear in the same cycle
    lines = 4'b1011; idle(4); reg_read(1'b1, v);
    lines = 4'b1010; idle(4);
    lines = 4'b1000;
    @(negedge clk); @(negedge clk);
    reg_read(1'b1, v); check("R4 read in set cycle", v, 8'hA1);
    reg_read(1'b1, v); check("R4 new flag kept", v, 8'h82);
    check("R4 irq after", {7'b0, modem_irq}, 8'h00);

    // R7 loopback ignores the lines
    lines = 4'b1011; idle(4); reg_read(1'b1, v);
    reg_write(1'b0, 8'h13);
    lines = 4'b0100; idle(4);
    check("R7 irq in loop", {7'b0, modem_irq}, 8'h00);
    reg_read(1'b1, v); check("R7 loop view", v, 8'h30);
    lines = 4'b0101; idle(4);
    reg_write(1'b0, 8'h08);
    idle(2);
    check("R7 irq after exit", {7'b0, modem_irq}, 8'h00);
    reg_read(1'b1, v); check("R7 levels tracked", v, 8'h50);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule